// File: doc/BRIEF.md
# Pipelined Bilinear Interpolator

This block blends four neighbouring 8-bit grayscale samples into one output sample using bilinear weighting. The four samples form a 2x2 patch: upper-left, upper-right, lower-left and lower-right. Two fractional weights place the output point inside the patch. The column weight gives the horizontal distance from the left pair. The row weight gives the vertical distance from the upper pair. Each weight is a 7-bit unsigned fraction in units of 1/128.

The datapath is a five-register pipeline and can take a new patch on every clock. Stage one forms the weight complements (128 minus the weight). Stage two forms the horizontal products for both rows. Stage three adds them into two row blends. Stage four weights each row blend by its vertical factor. Stage five adds the two terms and keeps the integer part. A valid bit travels beside the data.

The result register loads only when a valid item reaches the last stage, so the last result stays on the output while the pipeline is idle. Fetching the samples and computing the weights are done by the surrounding logic.

Top module: `bilerp_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state has `out_valid` = 0 and `out_pix` = 0. Likewise, the first cycle after reset is released shows `out_valid` = 0.
- R2: For each accepted item, `out_pix` equals the exact integer result floor(((128-c)(128-r)·UL + c(128-r)·UR + (128-c)r·LL + c·r·LR) / 16384), where c = `in_wcol` and r = `in_wrow`. The result always lies between the smallest and the largest of the four inputs.
- R3: An item sampled with `in_valid` = 1 at a rising edge shows up on `out_valid`/`out_pix` just after the fifth rising edge, counting the sampling edge as the first. `out_valid` always equals `in_valid` from five edges earlier.
- R4: Items may be presented on consecutive cycles without any gap. Each produces its own result, and results come out in input order.
- R5: When `in_wrow` = 0 and `in_wcol` = 0, `out_pix` equals `in_ul` exactly.
- R6: When `in_wcol` = 0, `in_ur` and `in_lr` have no effect. The result is floor(((128-r)·UL + r·LL)/128) and lies between UL and LL.
- R7: When `in_wrow` = 0, `in_ll` and `in_lr` have no effect. The result is floor(((128-c)·UL + c·UR)/128).
- R8: Every result is within 4 gray levels of the real-valued bilinear blend computed with the same weights.
- R9: In a cycle where `out_valid` is 0, `out_pix` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The input patch and weights are valid this cycle |
| in_ul | input | 8 | Upper-left sample |
| in_ur | input | 8 | Upper-right sample |
| in_ll | input | 8 | Lower-left sample |
| in_lr | input | 8 | Lower-right sample |
| in_wrow | input | 7 | Vertical weight, in units of 1/128 |
| in_wcol | input | 7 | Horizontal weight, in units of 1/128 |
| out_valid | output | 1 | `out_pix` carries a new result |
| out_pix | output | 8 | Interpolated sample |

## Verification
The checker assumes three things about the inputs:
- The samples and weights are stable and known at each rising edge where `in_valid` is high.
- The weights never exceed 127, which the port width guarantees.
- Reset is held for at least one edge before inputs are used.

The bench drives every input at the falling edge, so values are settled long before the next rising edge. It applies reset for three edges before any item. Its weights come from the full 7-bit range: zero on one or both axes, the maximum of 127, and random values. These items are presented back to back and with random idle gaps, so both throughput and the hold behaviour are exercised.

// File: rtl/bilerp_pkg.sv
package bilerp_pkg;
    // Default sample width and weight fraction width.
    localparam int unsigned PIX_W_DEF  = 8;
    localparam int unsigned FRAC_W_DEF = 7;
    // Number of register stages between the input and the result.
    localparam int unsigned STAGES     = 5;
endpackage

// File: rtl/bilerp_wprep.sv
// Stage 1: registers the patch and both weights, and forms the complements 2^FRAC_W - w.
// Assumes the weights are below 2^FRAC_W.
module bilerp_wprep #(
    parameter int unsigned PIX_W  = 8,
    parameter int unsigned FRAC_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  ul,
    input  logic [PIX_W-1:0]  ur,
    input  logic [PIX_W-1:0]  ll,
    input  logic [PIX_W-1:0]  lr,
    input  logic [FRAC_W-1:0] wrow,
    input  logic [FRAC_W-1:0] wcol,
    output logic [PIX_W-1:0]  q_ul,
    output logic [PIX_W-1:0]  q_ur,
    output logic [PIX_W-1:0]  q_ll,
    output logic [PIX_W-1:0]  q_lr,
    output logic [FRAC_W:0]   q_r,
    output logic [FRAC_W:0]   q_rc,
    output logic [FRAC_W:0]   q_c,
    output logic [FRAC_W:0]   q_cc
);
    localparam logic [FRAC_W:0] ONE = (FRAC_W+1)'(1) << FRAC_W;

    // Capture the patch, the weights and their complements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_ul <= '0; q_ur <= '0; q_ll <= '0; q_lr <= '0;
            q_r  <= '0; q_rc <= '0; q_c  <= '0; q_cc <= '0;
        end else begin
            q_ul <= ul; q_ur <= ur; q_ll <= ll; q_lr <= lr;
            q_r  <= {1'b0, wrow};
            q_rc <= ONE - {1'b0, wrow};
            q_c  <= {1'b0, wcol};
            q_cc <= ONE - {1'b0, wcol};
        end
    end
endmodule

// File: rtl/bilerp_hlerp.sv
// Stages 2 and 3 for one row: forms the two horizontal products, then adds them.
// Assumes wl + wr == 2^FRAC_W, so the sum fits in PIX_W+FRAC_W bits.
module bilerp_hlerp #(
    parameter int unsigned PIX_W  = 8,
    parameter int unsigned FRAC_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PIX_W-1:0]        left,
    input  logic [PIX_W-1:0]        right,
    input  logic [FRAC_W:0]         wl,
    input  logic [FRAC_W:0]         wr,
    output logic [PIX_W+FRAC_W-1:0] blend
);
    localparam int unsigned HW = PIX_W + FRAC_W;

    logic [HW-1:0] prod_l, prod_r;

    // Stage 2: weight each sample of the row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_l <= '0;
            prod_r <= '0;
        end else begin
            prod_l <= HW'(wl) * HW'(left);
            prod_r <= HW'(wr) * HW'(right);
        end
    end

    // Stage 3: add the two products into the row blend.
    always_ff @(posedge clk) begin
        if (!rst_n) blend <= '0;
        else        blend <= prod_l + prod_r;
    end
endmodule

// File: rtl/bilerp_vlerp.sv
// Stages 4 and 5: weights both row blends vertically, then adds them and keeps the integer part.
// Assumes the row weights sum to 2^FRAC_W, so the result fits in PIX_W bits.
module bilerp_vlerp #(
    parameter int unsigned PIX_W  = 8,
    parameter int unsigned FRAC_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [PIX_W+FRAC_W-1:0] top,
    input  logic [PIX_W+FRAC_W-1:0] bot,
    input  logic [FRAC_W:0]         wt,
    input  logic [FRAC_W:0]         wb,
    output logic [PIX_W-1:0]        pix
);
    localparam int unsigned VW = PIX_W + 2*FRAC_W;

    logic [VW-1:0] vt, vb, vsum;

    // Stage 4: weight each row blend by its vertical factor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vt <= '0;
            vb <= '0;
        end else begin
            vt <= VW'(top) * VW'(wt);
            vb <= VW'(bot) * VW'(wb);
        end
    end

    assign vsum = vt + vb;

    // Stage 5: load the truncated sum only for valid items, so the output holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    pix <= '0;
        else if (load) pix <= vsum[2*FRAC_W +: PIX_W];
    end
endmodule

// File: rtl/bilerp_vpipe.sv
// Shift register that carries the valid bit; each tap marks one stage as holding a live item.
module bilerp_vpipe #(
    parameter int unsigned DEPTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vin,
    output logic [DEPTH-1:0] taps
);
    // Shift the valid bit one stage per clock; reset empties the pipe.
    always_ff @(posedge clk) begin
        if (!rst_n) taps <= '0;
        else        taps <= {taps[DEPTH-2:0], vin};
    end
endmodule

// File: rtl/bilerp_top.sv
// Five-stage bilinear interpolator. It accepts one patch per clock and gives the result
// five edges later.
// Assumes the weights are fractions in units of 2^-FRAC_W.
module bilerp_top
    import bilerp_pkg::*;
#(
    parameter int unsigned PIX_W  = PIX_W_DEF,
    parameter int unsigned FRAC_W = FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_ul,
    input  logic [PIX_W-1:0]  in_ur,
    input  logic [PIX_W-1:0]  in_ll,
    input  logic [PIX_W-1:0]  in_lr,
    input  logic [FRAC_W-1:0] in_wrow,
    input  logic [FRAC_W-1:0] in_wcol,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    localparam int unsigned HW = PIX_W + FRAC_W;

    logic [STAGES-1:0] vtap;
    logic [PIX_W-1:0]  s1_ul, s1_ur, s1_ll, s1_lr;
    logic [FRAC_W:0]   s1_r, s1_rc, s1_c, s1_cc;
    logic [FRAC_W:0]   s2_r, s2_rc, s3_r, s3_rc;
    logic [PIX_W-1:0]  row_left  [2];
    logic [PIX_W-1:0]  row_right [2];
    logic [HW-1:0]     row_blend [2];

    bilerp_vpipe #(.DEPTH(STAGES)) u_vpipe (
        .clk(clk), .rst_n(rst_n), .vin(in_valid), .taps(vtap)
    );

    bilerp_wprep #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_wprep (
        .clk(clk), .rst_n(rst_n),
        .ul(in_ul), .ur(in_ur), .ll(in_ll), .lr(in_lr),
        .wrow(in_wrow), .wcol(in_wcol),
        .q_ul(s1_ul), .q_ur(s1_ur), .q_ll(s1_ll), .q_lr(s1_lr),
        .q_r(s1_r), .q_rc(s1_rc), .q_c(s1_c), .q_cc(s1_cc)
    );

    assign row_left[0]  = s1_ul;
    assign row_right[0] = s1_ur;
    assign row_left[1]  = s1_ll;
    assign row_right[1] = s1_lr;

    // One horizontal blender per row: index 0 is the upper row, index 1 the lower row.
    for (genvar g = 0; g < 2; g++) begin : g_row
        bilerp_hlerp #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_hlerp (
            .clk(clk), .rst_n(rst_n),
            .left(row_left[g]), .right(row_right[g]),
            .wl(s1_cc), .wr(s1_c),
            .blend(row_blend[g])
        );
    end

    // Delay the vertical factors by two stages so they meet the row blends at stage 4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_r <= '0; s2_rc <= '0; s3_r <= '0; s3_rc <= '0;
        end else begin
            s2_r <= s1_r; s2_rc <= s1_rc;
            s3_r <= s2_r; s3_rc <= s2_rc;
        end
    end

    bilerp_vlerp #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_vlerp (
        .clk(clk), .rst_n(rst_n), .load(vtap[STAGES-2]),
        .top(row_blend[0]), .bot(row_blend[1]),
        .wt(s3_rc), .wb(s3_r),
        .pix(out_pix)
    );

    assign out_valid = vtap[STAGES-1];
endmodule

// File: rtl/bilerp_checks.sv
// Property checker for bilerp_top. It is attached to every instance by the bind at the end of this file.
module bilerp_checks #(
    parameter int unsigned PIX_W  = 8,
    parameter int unsigned FRAC_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [PIX_W-1:0]  in_ul,
    input logic [PIX_W-1:0]  in_ur,
    input logic [PIX_W-1:0]  in_ll,
    input logic [PIX_W-1:0]  in_lr,
    input logic [FRAC_W-1:0] in_wrow,
    input logic [FRAC_W-1:0] in_wcol,
    input logic              out_valid,
    input logic [PIX_W-1:0]  out_pix
);
    logic [2:0]       since_rst;
    logic [PIX_W-1:0] lo_a, hi_a, lo_b, hi_b, qmin, qmax, cmin, cmax;

    // Count edges since reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 3'd5) since_rst <= since_rst + 3'd1;
    end

    // Bounds of the whole patch, and of the left column alone.
    always_comb begin
        lo_a = (in_ul < in_ur) ? in_ul : in_ur;
        hi_a = (in_ul < in_ur) ? in_ur : in_ul;
        lo_b = (in_ll < in_lr) ? in_ll : in_lr;
        hi_b = (in_ll < in_lr) ? in_lr : in_ll;
        qmin = (lo_a < lo_b) ? lo_a : lo_b;
        qmax = (hi_a > hi_b) ? hi_a : hi_b;
        cmin = (in_ul < in_ll) ? in_ul : in_ll;
        cmax = (in_ul < in_ll) ? in_ll : in_ul;
    end

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd1) |-> !out_valid);

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd5) |-> (out_valid == $past(in_valid, 5)));

    p_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd5 && out_valid)
        |-> (out_pix >= $past(qmin, 5) && out_pix <= $past(qmax, 5)));

    p_corner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd5 && out_valid && $past(in_wrow, 5) == '0 && $past(in_wcol, 5) == '0)
        |-> (out_pix == $past(in_ul, 5)));

    p_leftcol_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd5 && out_valid && $past(in_wcol, 5) == '0)
        |-> (out_pix >= $past(cmin, 5) && out_pix <= $past(cmax, 5)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 3'd0 && !out_valid) |-> $stable(out_pix));
endmodule

bind bilerp_top bilerp_checks #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/bilerp_top_tb.sv
module bilerp_top_tb;
    localparam int PW = 8;
    localparam int FW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [PW-1:0] in_ul = '0, in_ur = '0, in_ll = '0, in_lr = '0;
    logic [FW-1:0] in_wrow = '0, in_wcol = '0;
    logic          out_valid;
    logic [PW-1:0] out_pix;

    typedef struct {
        int    exp;
        real   rexp;
        int    stamp;
        string tag;
    } item_t;

    item_t sb_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    last_pix = 0;
    bit    seen = 1'b0;

    bilerp_top u_dut (.*);

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: presents one item at the falling edge and pushes its expected result.
    task automatic drive(input int ul, input int ur, input int ll, input int lr,
                         input int wr, input int wc, input string tag);
        item_t it;
        longint num;
        @(negedge clk);
        in_valid = 1'b1;
        in_ul = PW'(ul); in_ur = PW'(ur); in_ll = PW'(ll); in_lr = PW'(lr);
        in_wrow = FW'(wr); in_wcol = FW'(wc);
        num = longint'((128-wc)*(128-wr)*ul + wc*(128-wr)*ur + (128-wc)*wr*ll + wc*wr*lr);
        if (tag == "R6")      it.exp = ((128-wr)*ul + wr*ll) / 128;
        else if (tag == "R7") it.exp = ((128-wc)*ul + wc*ur) / 128;
        else if (tag == "R5") it.exp = ul;
        else                  it.exp = int'(num / 16384);
        it.rexp  = real'(num) / 16384.0;
        it.stamp = cyc;
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_ul = PW'($urandom); in_ur = PW'($urandom);
            in_wrow = FW'($urandom); in_wcol = FW'($urandom);
        end
    endtask

    // Monitor: compares each result with the head of the scoreboard; checks the hold behaviour otherwise.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3 unexpected out_valid", 1, 0);
                end else begin
                    item_t it;
                    real d;
                    it = sb_q.pop_front();
                    check(int'(out_pix) == it.exp, it.tag, int'(out_pix), it.exp);
                    check(cyc - it.stamp == 5, "R3 latency", cyc - it.stamp, 5);
                    d = real'(out_pix) - it.rexp;
                    if (d < 0.0) d = -d;
                    check(d <= 4.0, "R8 error bound", int'(out_pix), int'(it.rexp));
                end
                last_pix = int'(out_pix);
                seen = 1'b1;
            end else if (seen) begin
                check(int'(out_pix) == last_pix, "R9 hold", int'(out_pix), last_pix);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        check(out_pix == '0, "R1 reset pix", int'(out_pix), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 after release", int'(out_valid), 0);

        // R5: both weights zero pass the upper-left sample through.
        drive(200, 17, 99, 3, 0, 0, "R5");
        drive(0, 255, 255, 255, 0, 0, "R5");
        drive(255, 0, 0, 0, 0, 0, "R5");
        idle(7);
        // R6: column weight zero, right samples varied.
        drive(40, 0, 240, 0, 64, 0, "R6");
        drive(40, 255, 240, 255, 64, 0, "R6");
        drive(255, 13, 0, 200, 127, 0, "R6");
        // R7: row weight zero, lower samples varied.
        drive(10, 250, 0, 0, 0, 96, "R7");
        drive(10, 250, 255, 255, 0, 96, "R7");
        drive(0, 255, 77, 1, 0, 127, "R7");
        idle(3);
        // R2: extremes of weights and samples.
        drive(255, 255, 255, 255, 127, 127, "R2");
        drive(0, 0, 0, 255, 127, 127, "R2");
        drive(255, 255, 255, 255, 1, 1, "R2");
        drive(12, 34, 56, 78, 64, 64, "R2");
        // R4: back-to-back random items.
        for (int i = 0; i < 200; i++)
            drive($urandom_range(255), $urandom_range(255), $urandom_range(255),
                  $urandom_range(255), $urandom_range(127), $urandom_range(127), "R4");
        // R9/R2: random items separated by random gaps.
        for (int i = 0; i < 60; i++) begin
            drive($urandom_range(255), $urandom_range(255), $urandom_range(255),
                  $urandom_range(255), $urandom_range(127), $urandom_range(127), "R2");
            idle($urandom_range(3));
        end
        idle(10);
        check(sb_q.size() == 0, "R4 all results returned", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule